// File: doc/BRIEF.md
# Host interrupt and flow controller

This block sits between a serial host port and a streaming text processor. Bytes that the host sends are held in a first-in, first-out buffer of 256 bytes until the downstream consumer takes them. A ready/busy line tells the host when to pause. The block pulls this line low when the buffer is nearly full. It releases the line only after a good amount of space has been freed.

The block also keeps a sticky, active-low interrupt. Two events can raise it. The first is the end of an operation. The second is a need for more data, which fires when the buffer drains below a low-water mark while a conversion is running. Each event has its own enable bit in a communication-control register. A pending-status register records which events fired.

A read-interrupt command returns the pending bits and clears them in one step. An event that arrives in the same cycle as the clear is not lost. Both handshake outputs are open drain. They are modelled as pull-down enables: a 1 on the output means the pin is driven low.

Top module: `host_flow_ctrl`

## Requirements
- R1: After reset the buffer is empty, `rd_valid` is 0, `busy_pull` is 0 (line high, ready), `int_pull` is 0 and `rint_status` is 2'b00.
- R2: Accepted bytes come out on `rd_data` in the order they were written. `rd_valid` is 1 whenever at least one byte is held, and a byte is removed on each clock edge where `rd_valid` and `rd_ready` are both 1.
- R3: The buffer holds at most 256 bytes. A write offered while it holds 256 bytes is dropped and does not disturb the stored bytes.
- R4: Once the free space (256 minus occupancy) is below 2, `busy_pull` is 1 from the next clock edge.
- R5: Once the free space is at least 16, `busy_pull` is 0 from the next clock edge. When the free space is from 2 to 15, `busy_pull` keeps its previous value.
- R6: When occupancy falls from 32 or more to below 32 while `conv_active` is 1 and enable bit 1 is set, pending bit 1 (needs more data) is set one clock later. While `conv_active` is 0, this fall does not set the bit.
- R7: A pulse on `op_done` while enable bit 0 is set makes pending bit 0 (operation complete) 1 from the next clock edge.
- R8: An event whose enable bit is 0 leaves its pending bit and `int_pull` unchanged. Enable bits are loaded from `cfg_en` on a `cfg_wr` cycle, with bit 0 for operation complete and bit 1 for needs more data.
- R9: `int_pull` is 1 whenever any pending bit is 1. A pending bit stays set until a read-interrupt command, even if its enable bit is later cleared.
- R10: In a cycle with `rint_cmd` at 1, `rint_status` shows the pending bits, and they are cleared at that clock edge. Any enabled event in the same cycle remains pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Host byte offered this cycle |
| wr_data | input | 8 | Host byte |
| rd_ready | input | 1 | Consumer takes the head byte |
| rd_valid | output | 1 | Buffer holds a byte |
| rd_data | output | 8 | Head byte of the buffer |
| conv_active | input | 1 | A conversion is running |
| op_done | input | 1 | One-cycle pulse: operation finished |
| cfg_wr | input | 1 | Load the interrupt enable bits |
| cfg_en | input | 2 | Enable bits: bit 0 operation complete, bit 1 needs more data |
| rint_cmd | input | 1 | Read-interrupt command |
| rint_status | output | 2 | Pending bits: bit 0 operation complete, bit 1 needs more data |
| int_pull | output | 1 | 1 drives the interrupt pin low |
| busy_pull | output | 1 | 1 drives the ready/busy pin low (host must pause) |

## Verification
The bench fills the buffer one byte at a time from empty to past full, then drains it back to empty, and checks the ready/busy output against the hysteresis rule at every occupancy. A design with an off-by-one threshold, or with no hysteresis, would release the host too early or stall it too late. Writes offered at full are checked by draining exactly 256 bytes with the right contents. A design that overwrote the head or wrapped its count would deliver wrong or extra bytes.

The low-water event is checked at its crossing, both with a conversion running and without one. A design that fired on level instead of edge, or ignored `conv_active`, would raise the interrupt at the wrong moment. The bench also fires an event in the same cycle as a read-interrupt command, with an enable bit cleared both before and after an event. A design that lost the coincident event, or that cleared pending bits when the mask changed, would show a wrong interrupt state afterwards.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
    typedef struct packed {
        logic more;
        logic done;
    } irq_vec_t;
endpackage

// File: rtl/hfc_buffer.sv
module hfc_buffer #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } buf_state_t;

    buf_state_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    always_comb begin
        st_d  = st_q;
        do_wr = wr_valid && (st_q.cnt != CW'(DEPTH));
        do_rd = rd_ready && (st_q.cnt != '0);
        if (do_wr)
            st_d.wptr = (st_q.wptr == AW'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        if (do_rd)
            st_d.rptr = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        if (do_wr && !do_rd)
            st_d.cnt = st_q.cnt + 1'b1;
        else if (do_rd && !do_wr)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[st_q.wptr] <= wr_data;
    end

    assign rd_valid = (st_q.cnt != '0);
    assign rd_data  = mem[st_q.rptr];
    assign count    = st_q.cnt;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
    assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CW'(DEPTH)) && !rd_ready |=> st_q.cnt == CW'(DEPTH));
    assert_pop_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready && !wr_valid |=> st_q.cnt == $past(st_q.cnt) - 1'b1);
endmodule

// File: rtl/hfc_level.sv
module hfc_level #(
    parameter int DEPTH     = 256,
    parameter int BUSY_FREE = 2,
    parameter int READY_FREE = 16,
    parameter int LOW_WATER = 32,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count,
    input  logic          conv_active,
    output logic          busy,
    output logic          more_evt
);
    typedef struct packed {
        logic busy;
        logic below;
    } lvl_state_t;

    lvl_state_t st_d, st_q;
    logic [CW-1:0] free_sp;
    logic below_now;

    always_comb begin
        free_sp   = CW'(DEPTH) - count;
        below_now = count < CW'(LOW_WATER);
        st_d       = st_q;
        st_d.below = below_now;
        if (free_sp < CW'(BUSY_FREE))
            st_d.busy = 1'b1;
        else if (free_sp >= CW'(READY_FREE))
            st_d.busy = 1'b0;
        more_evt = conv_active && below_now && !st_q.below;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b0;
            st_q.below <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;

    assert_busy_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(DEPTH) - count) < CW'(BUSY_FREE) |=> busy);
    assert_busy_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (CW'(DEPTH) - count) >= CW'(READY_FREE) |=> !busy);
    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((CW'(DEPTH) - count) >= CW'(BUSY_FREE)) && ((CW'(DEPTH) - count) < CW'(READY_FREE))
        |=> $stable(busy));
endmodule

// File: rtl/hfc_irq.sv
module hfc_irq
    import hfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_en,
    input  logic       done_evt,
    input  logic       more_evt,
    input  logic       rint_cmd,
    output logic [1:0] pending,
    output logic       int_pull
);
    typedef struct packed {
        irq_vec_t en;
        irq_vec_t pend;
    } irq_state_t;

    irq_state_t st_d, st_q;
    irq_vec_t   fired;

    always_comb begin
        st_d       = st_q;
        fired.done = done_evt && st_q.en.done;
        fired.more = more_evt && st_q.en.more;
        if (cfg_wr) st_d.en = irq_vec_t'(cfg_en);
        st_d.pend = (rint_cmd ? irq_vec_t'(2'b00) : st_q.pend) | fired;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending  = st_q.pend;
    assign int_pull = st_q.pend.done | st_q.pend.more;

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_pull && !rint_cmd |=> int_pull);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rint_cmd && !done_evt && !more_evt |=> !int_pull);
    assert_keep_coincident_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rint_cmd && done_evt && st_q.en.done |=> pending[0]);
    assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pending[0] && !st_q.en.done |=> !pending[0]);
    assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt && st_q.en.done |=> pending[0]);
endmodule

// File: rtl/host_flow_ctrl.sv
module host_flow_ctrl #(
    parameter int DEPTH      = 256,
    parameter int W          = 8,
    parameter int BUSY_FREE  = 2,
    parameter int READY_FREE = 16,
    parameter int LOW_WATER  = 32,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         rd_ready,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    input  logic         conv_active,
    input  logic         op_done,
    input  logic         cfg_wr,
    input  logic [1:0]   cfg_en,
    input  logic         rint_cmd,
    output logic [1:0]   rint_status,
    output logic         int_pull,
    output logic         busy_pull
);
    logic [CW-1:0] occ;
    logic          more_evt;

    hfc_buffer #(.DEPTH(DEPTH), .W(W)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .count(occ)
    );

    hfc_level #(.DEPTH(DEPTH), .BUSY_FREE(BUSY_FREE), .READY_FREE(READY_FREE),
                .LOW_WATER(LOW_WATER)) u_lvl (
        .clk(clk), .rst_n(rst_n), .count(occ), .conv_active(conv_active),
        .busy(busy_pull), .more_evt(more_evt)
    );

    hfc_irq u_irq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .done_evt(op_done), .more_evt(more_evt), .rint_cmd(rint_cmd),
        .pending(rint_status), .int_pull(int_pull)
    );
endmodule

// File: tb/host_flow_ctrl_test.sv
module host_flow_ctrl_test;
    logic clk = 0;
    logic rst_n = 0;
    logic wr_valid = 0, rd_ready = 0, conv_active = 0, op_done = 0, cfg_wr = 0, rint_cmd = 0;
    logic [7:0] wr_data = 0;
    logic [1:0] cfg_en = 0;
    logic rd_valid, int_pull, busy_pull;
    logic [7:0] rd_data;
    logic [1:0] rint_status;

    int checks = 0, errors = 0;
    int occ = 0;
    logic exp_busy = 0;
    logic [1:0] exp_pend = 0;

    always #4 clk = ~clk;

    host_flow_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .conv_active(conv_active), .op_done(op_done), .cfg_wr(cfg_wr),
        .cfg_en(cfg_en), .rint_cmd(rint_cmd), .rint_status(rint_status),
        .int_pull(int_pull), .busy_pull(busy_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    task automatic model_busy();
        int fr = 256 - occ;
        if (fr < 2) exp_busy = 1;
        else if (fr >= 16) exp_busy = 0;
    endtask

    // one write, then an idle cycle, then sample
    task automatic push(input logic [7:0] d);
        @(negedge clk); wr_valid = 1; wr_data = d;
        @(negedge clk); wr_valid = 0;
        if (occ < 256) occ++;
        model_busy();
        @(negedge clk);
        chk("R4/R5 busy after write", busy_pull, exp_busy);
    endtask

    task automatic pop(input logic [7:0] d, input logic en_more);
        int prev;
        @(negedge clk);
        chk("R2 valid", rd_valid, 1);
        chk("R2 data", rd_data, d);
        rd_ready = 1;
        @(negedge clk); rd_ready = 0;
        prev = occ; occ--;
        if (prev >= 32 && occ < 32 && conv_active && en_more) exp_pend[1] = 1;
        model_busy();
        @(negedge clk);
        chk("R4/R5 busy after read", busy_pull, exp_busy);
        chk("R6 more-data pending", rint_status, exp_pend);
        chk("R9 interrupt line", int_pull, |exp_pend);
    endtask

    task automatic rint_now(input logic [1:0] exp_read, input logic [1:0] exp_after, input string req);
        @(negedge clk); rint_cmd = 1; #1;
        chk({req, " status read"}, rint_status, exp_read);
        @(negedge clk); rint_cmd = 0; op_done = 0;
        chk({req, " after clear"}, rint_status, exp_after);
        chk({req, " line after clear"}, int_pull, |exp_after);
        exp_pend = exp_after;
    endtask

    task automatic set_en(input logic [1:0] e);
        @(negedge clk); cfg_wr = 1; cfg_en = e;
        @(negedge clk); cfg_wr = 0;
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20; rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 busy", busy_pull, 0);
        chk("R1 int", int_pull, 0);
        chk("R1 status", rint_status, 0);

        set_en(2'b10);
        conv_active = 1;
        // R3 R4 R5: fill past full
        for (int i = 0; i < 259; i++) push(pat(i));
        // drain with conversion active: R2 R5 R6
        for (int i = 0; i < 256; i++) pop(pat(i), 1'b1);
        chk("R2 empty after drain", rd_valid, 0);
        chk("R6 fired once", rint_status, 2'b10);
        rint_now(2'b10, 2'b00, "R10");

        // R6 negative: crossing without conversion
        conv_active = 0;
        for (int i = 0; i < 40; i++) push(pat(i + 7));
        for (int i = 0; i < 20; i++) pop(pat(i + 7), 1'b1);
        chk("R6 no event when idle", int_pull, 0);
        for (int i = 20; i < 40; i++) pop(pat(i + 7), 1'b1);

        // R8: done masked
        @(negedge clk); op_done = 1;
        @(negedge clk); op_done = 0;
        @(negedge clk);
        chk("R8 masked done ignored", rint_status, 0);
        chk("R8 masked line", int_pull, 0);

        // R7: enabled done
        set_en(2'b01);
        @(negedge clk); op_done = 1;
        @(negedge clk); op_done = 0;
        chk("R7 done pending", rint_status, 2'b01);
        chk("R7 line low", int_pull, 1);

        // R9: disabling enable keeps pending
        set_en(2'b00);
        @(negedge clk);
        chk("R9 sticky after mask", rint_status, 2'b01);
        chk("R9 line stays", int_pull, 1);

        // R10: coincident event with clear stays pending
        set_en(2'b01);
        @(negedge clk); op_done = 1;
        rint_now(2'b01, 2'b01, "R10 coincident");
        rint_now(2'b01, 2'b00, "R10 final");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule